// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block translates a virtual page number into a physical page number by searching an inverted page table kept in memory. The table is an array of slots. Each slot holds eight entries, and each entry pairs a VPN with a PPN. When a request arrives, the walker folds the VPN into a slot index and adds the scaled index to a table base to find where the slot starts. It then reads the slot's entries one at a time and compares the stored VPN of each against the request.

If no entry of the first slot matches, the walker derives a second slot index with an alternate hash and scans that slot the same way. The first match ends the walk and returns the PPN. A walk that exhausts both slots reports a miss, and the request then passes to the software-managed backup table. Every response carries the number of entries that were read.

The walker has one read port toward memory and allows one read in flight at a time. A read may take any number of cycles to complete. The table base must stay stable while a walk is in progress.

Top module: `hpt_lookup`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0 until a request is accepted.
- R2: The first read of a walk goes to `tbl_base + 8*h`, where h is `(vpn[15:0] XOR vpn[31:16])` keeping only its low SLOT_BITS bits.
- R3: Within a slot, the walker reads consecutive entry addresses `slot_start + k` for k = 0, 1, ... . Each read is a one-cycle `mem_req` pulse. The next read is issued only after `mem_rvalid` has returned the previous one.
- R4: A memory word is `{valid[52], vpn[51:20], ppn[19:0]}`. An entry matches only when its valid bit is 1 and its VPN equals the requested VPN. An invalid entry with an equal VPN never matches.
- R5: The walk stops at the first matching entry in read order. No further reads are made. The response has `rsp_hit`=1, the entry's PPN, and `rsp_probes` equal to the number of reads issued.
- R6: When all eight entries of the first slot fail to match, the walker scans the slot at `tbl_base + 8*(~h)`, using the same SLOT_BITS-bit mask. `rsp_probes` then continues from 9 to 16.
- R7: When neither slot matches, the response has `rsp_hit`=0, `rsp_ppn`=0 and `rsp_probes`=16, after exactly 16 reads.
- R8: `rsp_valid` is a one-cycle pulse in the cycle after the `mem_rvalid` that decides the walk. `req_ready` is 0 from the cycle after acceptance through the response cycle, and it returns to 1 the cycle after the response.
- R9: A match on the last entry of the first slot returns a hit and makes no read of the second slot, even if the second slot also holds that VPN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tbl_base | input | ADDR_W | Word address of slot 0 of the table |
| req_valid | input | 1 | A translation request is presented |
| req_vpn | input | VPN_W | VPN to translate |
| req_ready | output | 1 | The walker is idle and accepts a request |
| mem_req | output | 1 | One-cycle read strobe toward memory |
| mem_addr | output | ADDR_W | Word address of the entry being read |
| mem_rvalid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 1+VPN_W+PPN_W | Entry word returned by memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 when a matching entry was found |
| rsp_ppn | output | PPN_W | PPN of the matching entry, or 0 on a miss |
| rsp_probes | output | PROBE_W | Number of entries read during the walk |

## Verification
Two decisions can fall on the same returned word: ending the walk on a match, and switching to the alternate slot after the eighth entry. The bench places a valid matching entry on the last entry of the first slot and a different PPN for the same VPN in the second slot. It then judges the response PPN, a probe count of 8, and the scoreboard's expected address list, which must not contain any read of the second slot. A variant places a match on the sixteenth entry, where a match and the miss decision coincide, and expects a hit with 16 probes.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } walk_state_e;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W     = 32,
  parameter int ADDR_W    = 32,
  parameter int SLOT_BITS = 10,
  parameter int WAY_BITS  = 3
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] prim_start,
  output logic [ADDR_W-1:0] alt_start
);

  localparam int HALF = VPN_W / 2;

  logic [HALF-1:0]      fold;
  logic [SLOT_BITS-1:0] prim_idx;
  logic [SLOT_BITS-1:0] alt_idx;

  // fold the two halves of the page number together
  always_comb begin
    fold     = vpn[HALF-1:0] ^ vpn[VPN_W-1:HALF];
    prim_idx = fold[SLOT_BITS-1:0];
    alt_idx  = ~prim_idx;
  end

  // each slot spans 2**WAY_BITS consecutive words
  always_comb begin
    prim_start = base + (ADDR_W'(prim_idx) << WAY_BITS);
    alt_start  = base + (ADDR_W'(alt_idx) << WAY_BITS);
  end

endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
  parameter int VPN_W = 32,
  parameter int PPN_W = 20
) (
  input  logic [VPN_W+PPN_W:0] entry,
  input  logic [VPN_W-1:0]     vpn,
  output logic                 hit,
  output logic [PPN_W-1:0]     ppn
);

  localparam int VALID_POS = VPN_W + PPN_W;

  logic             ent_valid;
  logic [VPN_W-1:0] ent_vpn;

  always_comb begin
    ent_valid = entry[VALID_POS];
    ent_vpn   = entry[VALID_POS-1:PPN_W];
    ppn       = entry[PPN_W-1:0];
    hit       = ent_valid && (ent_vpn == vpn);
  end

endmodule

// File: rtl/hpt_walk_ctrl.sv
module hpt_walk_ctrl
  import hpt_pkg::*;
#(
  parameter int VPN_W    = 32,
  parameter int PPN_W    = 20,
  parameter int ADDR_W   = 32,
  parameter int WAYS     = 8,
  parameter int WAY_BITS = 3,
  parameter int PROBE_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VPN_W-1:0]   req_vpn,
  output logic               req_ready,
  output logic [VPN_W-1:0]   cur_vpn,
  input  logic [ADDR_W-1:0]  prim_start,
  input  logic [ADDR_W-1:0]  alt_start,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic               ent_hit,
  input  logic [PPN_W-1:0]   ent_ppn,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [PROBE_W-1:0] rsp_probes
);

  localparam logic [WAY_BITS-1:0] LAST_WAY  = WAY_BITS'(WAYS - 1);
  localparam int                  MAX_PROBE = 2 * WAYS;

  walk_state_e         state_q, state_n;
  logic [VPN_W-1:0]    vpn_q, vpn_n;
  logic [WAY_BITS-1:0] way_q, way_n;
  logic                alt_q, alt_n;
  logic [PROBE_W-1:0]  probes_q, probes_n;
  logic                hit_q, hit_n;
  logic [PPN_W-1:0]    ppn_q, ppn_n;
  logic                vpn_en;
  logic                res_en;

  // next-state logic
  always_comb begin
    state_n  = state_q;
    vpn_n    = vpn_q;
    way_n    = way_q;
    alt_n    = alt_q;
    probes_n = probes_q;
    hit_n    = hit_q;
    ppn_n    = ppn_q;
    vpn_en   = 1'b0;
    res_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          vpn_en   = 1'b1;
          vpn_n    = req_vpn;
          way_n    = '0;
          alt_n    = 1'b0;
          probes_n = '0;
          state_n  = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        probes_n = probes_q + PROBE_W'(1);
        state_n  = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rvalid) begin
          if (ent_hit) begin
            res_en  = 1'b1;
            hit_n   = 1'b1;
            ppn_n   = ent_ppn;
            state_n = ST_RESP;
          end else if (way_q == LAST_WAY) begin
            if (alt_q) begin
              res_en  = 1'b1;
              hit_n   = 1'b0;
              ppn_n   = '0;
              state_n = ST_RESP;
            end else begin
              alt_n   = 1'b1;
              way_n   = '0;
              state_n = ST_ISSUE;
            end
          end else begin
            way_n   = way_q + WAY_BITS'(1);
            state_n = ST_ISSUE;
          end
        end
      end
      ST_RESP: begin
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      way_q    <= '0;
      alt_q    <= 1'b0;
      probes_q <= '0;
    end else begin
      state_q  <= state_n;
      way_q    <= way_n;
      alt_q    <= alt_n;
      probes_q <= probes_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q <= '0;
    end else if (vpn_en) begin
      vpn_q <= vpn_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      ppn_q <= '0;
    end else if (res_en) begin
      hit_q <= hit_n;
      ppn_q <= ppn_n;
    end
  end

  // outputs
  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    mem_req    = (state_q == ST_ISSUE);
    mem_addr   = (alt_q ? alt_start : prim_start) + ADDR_W'(way_q);
    cur_vpn    = vpn_q;
    rsp_valid  = (state_q == ST_RESP);
    rsp_hit    = hit_q;
    rsp_ppn    = ppn_q;
    rsp_probes = probes_q;
  end

  // R3: read data only arrives while a read is outstanding
  a_r3_data_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (state_q == ST_WAIT));

  // R8: single-cycle response, then ready again
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R5: probe count lies within the two slots
  a_r5_probe_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_probes >= PROBE_W'(1) && rsp_probes <= PROBE_W'(MAX_PROBE)));

  // R7: a miss has read every entry of both slots
  a_r7_miss_full_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_probes == PROBE_W'(MAX_PROBE) && rsp_ppn == '0));

  // R9: a matching word ends the walk with a hit, even on the last entry of a slot
  a_r9_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && mem_rvalid && ent_hit) |=> (rsp_valid && rsp_hit && !mem_req));

endmodule

// File: rtl/hpt_lookup.sv
module hpt_lookup #(
  parameter int VPN_W     = 32,
  parameter int PPN_W     = 20,
  parameter int ADDR_W    = 32,
  parameter int SLOT_BITS = 10,
  parameter int WAYS      = 8,
  localparam int WAY_BITS = $clog2(WAYS),
  localparam int PROBE_W  = $clog2(2 * WAYS + 1),
  localparam int ENTRY_W  = 1 + VPN_W + PPN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  tbl_base,
  input  logic               req_valid,
  input  logic [VPN_W-1:0]   req_vpn,
  output logic               req_ready,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [ENTRY_W-1:0] mem_rdata,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [PROBE_W-1:0] rsp_probes
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [VPN_W-1:0]  cur_vpn;
  logic [ADDR_W-1:0] prim_start;
  logic [ADDR_W-1:0] alt_start;
  logic              ent_hit;
  logic [PPN_W-1:0]  ent_ppn;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  always_comb rst_int_n = rst_sync_q[1];

  hpt_hash #(
    .VPN_W    (VPN_W),
    .ADDR_W   (ADDR_W),
    .SLOT_BITS(SLOT_BITS),
    .WAY_BITS (WAY_BITS)
  ) u_hash (
    .vpn       (cur_vpn),
    .base      (tbl_base),
    .prim_start(prim_start),
    .alt_start (alt_start)
  );

  hpt_match #(
    .VPN_W(VPN_W),
    .PPN_W(PPN_W)
  ) u_match (
    .entry(mem_rdata),
    .vpn  (cur_vpn),
    .hit  (ent_hit),
    .ppn  (ent_ppn)
  );

  hpt_walk_ctrl #(
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .ADDR_W  (ADDR_W),
    .WAYS    (WAYS),
    .WAY_BITS(WAY_BITS),
    .PROBE_W (PROBE_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_vpn   (req_vpn),
    .req_ready (req_ready),
    .cur_vpn   (cur_vpn),
    .prim_start(prim_start),
    .alt_start (alt_start),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .ent_hit   (ent_hit),
    .ent_ppn   (ent_ppn),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_ppn   (rsp_ppn),
    .rsp_probes(rsp_probes)
  );

endmodule

// File: tb/hpt_lookup_test.sv
module hpt_lookup_test;

  localparam int SB      = 4;
  localparam int PW      = 5;
  localparam logic [31:0] BASE = 32'h80;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vpn;
  logic        req_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [52:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [19:0] rsp_ppn;
  logic [PW-1:0] rsp_probes;

  hpt_lookup #(.SLOT_BITS(SB)) uut (
    .clk(clk), .rst_n(rst_n), .tbl_base(BASE),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_probes(rsp_probes)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [52:0] mem [0:511];

  // memory model with varying latency (1..3 cycles)
  logic        pend;
  logic [1:0]  cnt;
  logic [1:0]  lat_sel;
  logic [31:0] addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; cnt <= 2'd0; lat_sel <= 2'd0; addr_q <= '0;
      mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        pend    <= 1'b1;
        addr_q  <= mem_addr;
        cnt     <= (lat_sel == 2'd2) ? 2'd3 : lat_sel + 2'd1;
        lat_sel <= (lat_sel == 2'd2) ? 2'd0 : lat_sel + 2'd1;
      end else if (pend) begin
        if (cnt == 2'd1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[addr_q[8:0]];
          pend       <= 1'b0;
        end else begin
          cnt <= cnt - 2'd1;
        end
      end
    end
  end

  // scoreboard queues
  logic [31:0] exp_addr_q[$];
  string       exp_addr_tag[$];
  logic        exp_hit_q[$];
  logic [19:0] exp_ppn_q[$];
  int          exp_probes_q[$];
  string       exp_rsp_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor
  bit chk_after_rsp = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (chk_after_rsp) begin
        check(!rsp_valid && req_ready, "R8", "rsp pulse / ready after response",
              {30'd0, rsp_valid, req_ready}, 32'd1);
        chk_after_rsp = 0;
      end
      if (mem_req) begin
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R5", "unexpected read", mem_addr, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] ea;
          string t;
          ea = exp_addr_q.pop_front();
          t  = exp_addr_tag.pop_front();
          check(mem_addr == ea, t, "read address", mem_addr, ea);
        end
      end
      if (rsp_valid) begin
        if (exp_hit_q.size() == 0) begin
          check(1'b0, "R8", "unexpected response", 32'd0, 32'd1);
        end else begin
          logic eh;
          logic [19:0] ep;
          int epr;
          string t;
          eh  = exp_hit_q.pop_front();
          ep  = exp_ppn_q.pop_front();
          epr = exp_probes_q.pop_front();
          t   = exp_rsp_tag.pop_front();
          check(rsp_hit == eh, t, "hit", {31'd0, rsp_hit}, {31'd0, eh});
          check(rsp_ppn == ep, t, "ppn", {12'd0, rsp_ppn}, {12'd0, ep});
          check(int'(rsp_probes) == epr, t, "probes", {27'd0, rsp_probes}, epr);
          check(!req_ready, "R8", "ready low in response cycle", {31'd0, req_ready}, 32'd0);
          check(exp_addr_q.size() == 0, "R5", "reads left unissued",
                exp_addr_q.size(), 32'd0);
          chk_after_rsp = 1;
        end
      end
    end
  end

  function automatic logic [52:0] mk(input bit v, input logic [31:0] vpn, input logic [19:0] ppn);
    return {v, vpn, ppn};
  endfunction

  task automatic put(input int slot, input int way, input bit v,
                     input logic [31:0] vpn, input logic [19:0] ppn);
    logic [31:0] a;
    a = BASE + 32'(slot) * 8 + 32'(way);
    mem[a[8:0]] = mk(v, vpn, ppn);
  endtask

  // driver: computes the expected walk from the requirements, then issues it
  task automatic lookup(input logic [31:0] vpn, input string tag);
    logic [15:0]   fold;
    logic [SB-1:0] h;
    bit            found;
    int            probes;
    logic [19:0]   ppn;
    found  = 0;
    probes = 0;
    ppn    = '0;
    fold   = vpn[15:0] ^ vpn[31:16];
    h      = fold[SB-1:0];
    for (int pass = 0; pass < 2; pass++) begin
      logic [SB-1:0] slot;
      slot = (pass == 0) ? h : ~h;
      for (int w = 0; w < 8; w++) begin
        if (!found) begin
          logic [31:0] a;
          logic [52:0] e;
          a = BASE + 32'(slot) * 8 + 32'(w);
          exp_addr_q.push_back(a);
          exp_addr_tag.push_back(pass == 0 ? (w == 0 ? "R2" : "R3") : "R6");
          probes++;
          e = mem[a[8:0]];
          if (e[52] && e[51:20] == vpn) begin
            found = 1;
            ppn   = e[19:0];
          end
        end
      end
    end
    exp_hit_q.push_back(found);
    exp_ppn_q.push_back(ppn);
    exp_probes_q.push_back(probes);
    exp_rsp_tag.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = vpn;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_hit_q.size() != 0) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    req_valid = 1'b0;
    req_vpn   = '0;
    rst_n     = 1'b0;
    for (int i = 0; i < 512; i++) mem[i] = mk(1'b1, 32'hFFFF_0000 | 32'(i), 20'(i));
    // R2 / R5: XOR fold of upper half, hit on first entry
    put(7, 0, 1'b1, 32'h0007_0000, 20'h1A001);
    // R4: invalid entry with equal VPN is skipped
    put(2, 2, 1'b0, 32'h0000_0002, 20'h00BAD);
    put(2, 5, 1'b1, 32'h0000_0002, 20'h2B005);
    // R9: match on last entry of first slot, decoy in second slot
    put(3, 7, 1'b1, 32'h0000_0003, 20'h3C007);
    put(12, 0, 1'b1, 32'h0000_0003, 20'hDEAD0);
    // R6: hit in second slot
    put(11, 3, 1'b1, 32'h0000_0004, 20'h4D003);
    // R7: only invalid copies
    put(5, 1, 1'b0, 32'h0000_0005, 20'h55555);
    put(10, 6, 1'b0, 32'h0000_0005, 20'h56666);
    // R6 / R8: hit on the very last probe
    put(9, 7, 1'b1, 32'h0000_0006, 20'h6E007);
    // R5: two matches, first wins
    put(1, 1, 1'b1, 32'h0001_0000, 20'h71111);
    put(1, 4, 1'b1, 32'h0001_0000, 20'h74444);
    // R2 / R6: fold gives slot 15, hit in slot 0
    put(0, 0, 1'b1, 32'h00F0_0F0F, 20'h0F00F);

    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "R1", "state during reset",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "R1", "state after reset",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);

    lookup(32'h0007_0000, "R2");
    lookup(32'h0000_0002, "R4");
    lookup(32'h0000_0003, "R9");
    lookup(32'h0000_0004, "R6");
    lookup(32'h0000_0005, "R7");
    lookup(32'h0000_0006, "R8");
    lookup(32'h0001_0000, "R5");
    lookup(32'h0007_0000, "R5");
    lookup(32'h00F0_0F0F, "R6");
    repeat (4) @(negedge clk);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule